// File: doc/BRIEF.md
# Flash Command Decoder and Write/Erase Controller

This block sits behind the bus side of a block-erasable flash array. Bus write strobes carry command bytes on the low eight data lines. A small sequencer turns those bytes into three things: a choice of what the read port returns (array contents, identification codes or the status byte), single-word or single-byte programming, and whole-block erasure. A behavioural storage array holds the data. A fixed busy interval stands in for real cell timing, and its length is set by a parameter.

Changes to the array always take two bus writes. A setup command comes first, then a confirm cycle. The confirm is carried out only when the programming-supply flag is high. If the target is the boot block, the unlock flag must also be high. The address space is cut into seven erase blocks whose sizes are fixed fractions of the total. A build parameter puts the boot block at the highest or the lowest addresses. Every refused or malformed operation leaves a sticky error flag in the status byte.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears all error flags, ends any operation and selects array reads. Array contents are kept.
- R2: In array mode, word mode (`byte_mode`=0) returns the word at `addr`. Byte mode returns the low byte when `byte_lsb`=0 and the high byte when `byte_lsb`=1, on bits 7:0, with bits 15:8 zero.
- R3: Only `wdata[7:0]` is decoded as a command, and bits 15:8 are ignored. FFh selects array reads, 90h identification reads and 70h status reads. 50h clears the error flags. 20h is erase setup, 10h or 40h is program setup, and any other code is ignored.
- R4: Identification reads return 002Ch when `addr[0]`=0. When `addr[0]`=1 they return 44B0h if the boot block is at the top and 44B1h if it is at the bottom. In byte mode bits 15:8 read 00h.
- R5: After program setup, the next write stores `wdata` at `addr`. In byte mode only the lane chosen by `byte_lsb` is written, from `wdata[7:0]`, and the other lane is kept.
- R6: Erase setup followed by D0h sets every word of the block that holds the confirm-cycle `addr` to FFFFh. Other blocks are left unchanged.
- R7: With N words, the block sizes, counted from the boot end, are N/32 (boot), N/64, N/64, 3N/16, N/4, N/4 and N/4. `TOP_BOOT`=1 places the boot end at address N-1, and `TOP_BOOT`=0 places it at address 0.
- R8: If `vpp_ok` is low in a confirm cycle, nothing changes. The supply flag (bit 3) is set, together with bit 4 for a program or bit 5 for an erase.
- R9: A program or erase aimed at the boot block also needs `boot_unlock`. Without it nothing changes and bit 4 (program) or bit 5 (erase) is set. Other blocks need no unlock.
- R10: The status byte layout is bit 7 ready, bit 6 suspended (always 0), bit 5 erase error, bit 4 program error and bit 3 supply error. Bits 2:0 are 0 and it reads with bits 15:8 = 0. Any setup command or confirm cycle selects status reads.
- R11: After an accepted confirm, the block is busy for exactly `BUSY_CYC` cycles. During that time reads return the status byte whatever the read mode, and bus writes are ignored.
- R12: A byte other than D0h after erase setup erases nothing. It sets bits 4 and 5 and selects status reads.
- R13: Error flags stay set until a 50h command or reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| addr | input | AW | Word address |
| byte_lsb | input | 1 | Byte lane select in byte mode |
| byte_mode | input | 1 | 1 selects 8-bit data path |
| wdata | input | 16 | Write data; command byte in bits 7:0 |
| vpp_ok | input | 1 | Programming supply present |
| boot_unlock | input | 1 | Boot block unlock condition present |
| rd_data | output | 16 | Read port, combinational from address and mode |

## Verification
The bench programs every address of a small array with distinct words, using both program codes in turn and random upper command bits. It then reads all words in both byte lanes, which separates lane and address errors. One erase is aimed at every block in turn while two builds with opposite boot placement receive the same stimulus. Each address's survival therefore exposes any shifted block boundary or mirrored map. Refusals are tested one at a time: supply off, boot locked, and a bad confirm byte. The locked attempt goes to an address that is the boot block in one build and a main block in the other, so one build must refuse and the other must succeed. The busy window is sampled on every cycle with a command issued inside it.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        SRC_ARRAY,
        SRC_IDENT,
        SRC_STATUS
    } rd_src_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_PROG_SETUP,
        SQ_ERASE_SETUP,
        SQ_BUSY
    } seq_state_e;

    typedef struct packed {
        logic ready;
        logic suspended;
        logic erase_err;
        logic prog_err;
        logic supply_err;
    } stat_t;

    localparam logic [7:0] OP_READ_ARRAY = 8'hFF;
    localparam logic [7:0] OP_IDENT      = 8'h90;
    localparam logic [7:0] OP_READ_STAT  = 8'h70;
    localparam logic [7:0] OP_CLEAR_STAT = 8'h50;
    localparam logic [7:0] OP_ERASE      = 8'h20;
    localparam logic [7:0] OP_CONFIRM    = 8'hD0;
    localparam logic [7:0] OP_PROG_A     = 8'h10;
    localparam logic [7:0] OP_PROG_B     = 8'h40;

    localparam logic [7:0] MAKER_CODE    = 8'h2C;
    localparam logic [7:0] DEV_HI_CODE   = 8'h44;
    localparam logic [2:0] BOOT_BLK      = 3'd0;

    function automatic logic [7:0] dev_code(input bit top_boot);
        return top_boot ? 8'hB0 : 8'hB1;
    endfunction

    function automatic logic [7:0] stat_byte(input stat_t s);
        return {s.ready, s.suspended, s.erase_err, s.prog_err, s.supply_err, 3'b000};
    endfunction

    // Block index counted from the boot end: 0 boot, 1..2 parameter,
    // 3 three-sixteenths main, 4..6 quarter mains.
    function automatic logic [2:0] blk_of(input int unsigned a,
                                          input int unsigned aw,
                                          input bit top_boot);
        int unsigned n;
        int unsigned x;
        n = 32'd1 << aw;
        x = top_boot ? a : (n - 32'd1 - a);
        if (x >= n - (n >> 5))                   return 3'd0;
        else if (x >= n - (n >> 5) - (n >> 6))   return 3'd1;
        else if (x >= n - (n >> 4))              return 3'd2;
        else if (x >= n - (n >> 2))              return 3'd3;
        else if (x >= (n >> 1))                  return 3'd4;
        else if (x >= (n >> 2))                  return 3'd5;
        else                                     return 3'd6;
    endfunction

endpackage

// File: rtl/fcw_blkdec.sv
module fcw_blkdec
    import flash_cmd_pkg::*;
#(
    parameter int AW       = 10,
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic [AW-1:0] addr,
    output logic [2:0]    blk,
    output logic          is_boot
);
    always_comb begin
        blk     = blk_of(32'(addr), AW, TOP_BOOT);
        is_boot = (blk == BOOT_BLK);
    end
endmodule

// File: rtl/fcw_array.sv
module fcw_array
    import flash_cmd_pkg::*;
#(
    parameter int AW       = 10,
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic          clk,
    input  logic          wr_go,
    input  logic          er_go,
    input  logic [AW-1:0] wa,
    input  logic [15:0]   wd,
    input  logic [1:0]    lane_mask,
    input  logic [2:0]    er_blk,
    input  logic [AW-1:0] ra,
    output logic [15:0]   rdata
);
    localparam int DEPTH = 1 << AW;

    logic [15:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (er_go && (blk_of(i, AW, TOP_BOOT) == er_blk))
                mem[i] <= 16'hFFFF;
        end
        if (wr_go) begin
            if (lane_mask[0]) mem[wa][7:0]  <= wd[7:0];
            if (lane_mask[1]) mem[wa][15:8] <= wd[15:8];
        end
    end

    assign rdata = mem[ra];
endmodule

// File: rtl/fcw_seq.sv
module fcw_seq
    import flash_cmd_pkg::*;
#(
    parameter int BUSY_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] cmd,
    input  logic       vpp_ok,
    input  logic       boot_unlock,
    input  logic       tgt_boot,
    output logic       go,
    output logic       commit,
    output logic       op_erase,
    output logic       busy,
    output logic       in_psetup,
    output logic       in_esetup,
    output rd_src_e    rd_src,
    output stat_t      stat
);
    localparam int CW = $clog2(BUSY_CYC + 1);

    seq_state_e   st;
    logic [CW-1:0] cnt;
    logic          er_err, pg_err, sp_err;
    logic          confirm_cyc;
    logic          locked;

    assign in_psetup   = (st == SQ_PROG_SETUP);
    assign in_esetup   = (st == SQ_ERASE_SETUP);
    assign busy        = (st == SQ_BUSY);
    assign confirm_cyc = wr_en && (in_psetup || (in_esetup && cmd == OP_CONFIRM));
    assign locked      = tgt_boot && !boot_unlock;
    assign go          = confirm_cyc && vpp_ok && !locked;
    assign commit      = busy && (cnt == '0);

    always_comb begin
        stat.ready      = !busy;
        stat.suspended  = 1'b0;
        stat.erase_err  = er_err;
        stat.prog_err   = pg_err;
        stat.supply_err = sp_err;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SQ_IDLE;
            cnt      <= '0;
            er_err   <= 1'b0;
            pg_err   <= 1'b0;
            sp_err   <= 1'b0;
            op_erase <= 1'b0;
            rd_src   <= SRC_ARRAY;
        end else begin
            unique case (st)
                SQ_IDLE: if (wr_en) begin
                    unique case (cmd)
                        OP_READ_ARRAY: rd_src <= SRC_ARRAY;
                        OP_IDENT:      rd_src <= SRC_IDENT;
                        OP_READ_STAT:  rd_src <= SRC_STATUS;
                        OP_CLEAR_STAT: begin
                            er_err <= 1'b0;
                            pg_err <= 1'b0;
                            sp_err <= 1'b0;
                        end
                        OP_ERASE: begin
                            st     <= SQ_ERASE_SETUP;
                            rd_src <= SRC_STATUS;
                        end
                        OP_PROG_A, OP_PROG_B: begin
                            st     <= SQ_PROG_SETUP;
                            rd_src <= SRC_STATUS;
                        end
                        default: ;
                    endcase
                end
                SQ_PROG_SETUP, SQ_ERASE_SETUP: if (wr_en) begin
                    rd_src <= SRC_STATUS;
                    if (in_esetup && cmd != OP_CONFIRM) begin
                        er_err <= 1'b1;
                        pg_err <= 1'b1;
                        st     <= SQ_IDLE;
                    end else if (!vpp_ok || locked) begin
                        if (!vpp_ok) sp_err <= 1'b1;
                        if (in_esetup) er_err <= 1'b1;
                        else           pg_err <= 1'b1;
                        st <= SQ_IDLE;
                    end else begin
                        op_erase <= in_esetup;
                        cnt      <= CW'(BUSY_CYC - 1);
                        st       <= SQ_BUSY;
                    end
                end
                SQ_BUSY: begin
                    if (cnt == '0) st <= SQ_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int AW       = 10,
    parameter bit TOP_BOOT = 1'b1,
    parameter int BUSY_CYC = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic          byte_lsb,
    input  logic          byte_mode,
    input  logic [15:0]   wdata,
    input  logic          vpp_ok,
    input  logic          boot_unlock,
    output logic [15:0]   rd_data
);
    logic [2:0]    cur_blk;
    logic          tgt_boot;
    logic          go, commit, op_erase, busy, in_wsetup, in_esetup;
    rd_src_e       rd_src, src_eff;
    stat_t         stat;
    logic [7:0]    stat_b;
    logic [AW-1:0] j_addr;
    logic [15:0]   j_data;
    logic [1:0]    j_mask;
    logic [2:0]    j_blk;
    logic [15:0]   arr_word;
    logic [15:0]   id_word;

    fcw_blkdec #(.AW(AW), .TOP_BOOT(TOP_BOOT)) u_dec (
        .addr    (addr),
        .blk     (cur_blk),
        .is_boot (tgt_boot)
    );

    fcw_seq #(.BUSY_CYC(BUSY_CYC)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .cmd         (wdata[7:0]),
        .vpp_ok      (vpp_ok),
        .boot_unlock (boot_unlock),
        .tgt_boot    (tgt_boot),
        .go          (go),
        .commit      (commit),
        .op_erase    (op_erase),
        .busy        (busy),
        .in_psetup   (in_wsetup),
        .in_esetup   (in_esetup),
        .rd_src      (rd_src),
        .stat        (stat)
    );

    // Job latch: captured on the accepted confirm cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            j_addr <= '0;
            j_data <= '0;
            j_mask <= '0;
            j_blk  <= '0;
        end else if (go) begin
            j_addr <= addr;
            j_blk  <= cur_blk;
            j_data <= byte_mode ? {wdata[7:0], wdata[7:0]} : wdata;
            j_mask <= byte_mode ? (byte_lsb ? 2'b10 : 2'b01) : 2'b11;
        end
    end

    fcw_array #(.AW(AW), .TOP_BOOT(TOP_BOOT)) u_arr (
        .clk       (clk),
        .wr_go     (commit && !op_erase),
        .er_go     (commit && op_erase),
        .wa        (j_addr),
        .wd        (j_data),
        .lane_mask (j_mask),
        .er_blk    (j_blk),
        .ra        (addr),
        .rdata     (arr_word)
    );

    assign stat_b  = stat_byte(stat);
    assign src_eff = busy ? SRC_STATUS : rd_src;
    assign id_word = addr[0] ? {DEV_HI_CODE, dev_code(TOP_BOOT)} : {8'h00, MAKER_CODE};

    always_comb begin
        unique case (src_eff)
            SRC_ARRAY:
                rd_data = byte_mode ? {8'h00, (byte_lsb ? arr_word[15:8] : arr_word[7:0])}
                                    : arr_word;
            SRC_IDENT:
                rd_data = byte_mode ? {8'h00, id_word[7:0]} : id_word;
            default:
                rd_data = {8'h00, stat_b};
        endcase
    end
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
    parameter int BUSY_CYC = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [15:0] wdata,
    input logic        vpp_ok,
    input logic        boot_unlock,
    input logic [15:0] rd_data,
    input logic        busy,
    input logic        in_wsetup,
    input logic        in_esetup,
    input logic        tgt_boot,
    input logic [7:0]  stat_b
);
    logic idle;
    logic confirm;
    int   run;

    assign idle    = !busy && !in_wsetup && !in_esetup;
    assign confirm = wr_en && (in_wsetup || (in_esetup && wdata[7:0] == 8'hD0));

    always_ff @(posedge clk) begin
        if (rst)       run <= 0;
        else if (busy) run <= run + 1;
        else           run <= 0;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!busy && stat_b[5:3] == 3'b000));

    assert_busy_reads_status_R11: assert property (@(posedge clk) disable iff (rst)
        busy |-> (rd_data == {8'h00, stat_b} && !rd_data[7]));

    assert_busy_window_R11: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run < BUSY_CYC));

    assert_no_supply_R8: assert property (@(posedge clk) disable iff (rst)
        (confirm && !vpp_ok) |=> (!busy && stat_b[3]));

    assert_boot_lock_R9: assert property (@(posedge clk) disable iff (rst)
        (confirm && vpp_ok && tgt_boot && !boot_unlock) |=> (!busy && (stat_b[4] || stat_b[5])));

    assert_bad_confirm_R12: assert property (@(posedge clk) disable iff (rst)
        (in_esetup && wr_en && wdata[7:0] != 8'hD0) |=> (stat_b[5:4] == 2'b11 && !busy));

    assert_clear_R13: assert property (@(posedge clk) disable iff (rst)
        (idle && wr_en && wdata[7:0] == 8'h50) |=> (stat_b[5:3] == 3'b000));

    assert_sticky_R13: assert property (@(posedge clk) disable iff (rst)
        (stat_b[4] && !(idle && wr_en && wdata[7:0] == 8'h50)) |=> stat_b[4]);
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.BUSY_CYC(BUSY_CYC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wdata       (wdata),
    .vpp_ok      (vpp_ok),
    .boot_unlock (boot_unlock),
    .rd_data     (rd_data),
    .busy        (busy),
    .in_wsetup   (in_wsetup),
    .in_esetup   (in_esetup),
    .tgt_boot    (tgt_boot),
    .stat_b      (stat_b)
);

// File: tb/sim_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_flash_cmd_ctrl;
    localparam int AW = 6;
    localparam int N  = 1 << AW;
    localparam int BC = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          byte_lsb = 1'b0;
    logic          byte_mode = 1'b0;
    logic [15:0]   wdata = '0;
    logic          vpp_ok = 1'b1;
    logic          boot_unlock = 1'b1;
    logic [15:0]   rdT, rdB;

    always #2.5 clk = ~clk;

    flash_cmd_ctrl #(.AW(AW), .TOP_BOOT(1'b1), .BUSY_CYC(BC)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .byte_lsb(byte_lsb),
        .byte_mode(byte_mode), .wdata(wdata), .vpp_ok(vpp_ok),
        .boot_unlock(boot_unlock), .rd_data(rdT));

    flash_cmd_ctrl #(.AW(AW), .TOP_BOOT(1'b0), .BUSY_CYC(BC)) u1 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .byte_lsb(byte_lsb),
        .byte_mode(byte_mode), .wdata(wdata), .vpp_ok(vpp_ok),
        .boot_unlock(boot_unlock), .rd_data(rdB));

    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 0;
    bit          prog_alt = 0;
    logic [7:0]  junk = 8'h3C;
    logic [15:0] shT [N];
    logic [15:0] shB [N];

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R7: walk block sizes from the boot end.
    function automatic int blk_exp(input int a, input bit top);
        int sz [7];
        int x, edge_lo;
        sz[0] = N / 32; sz[1] = N / 64; sz[2] = N / 64; sz[3] = 3 * N / 16;
        sz[4] = N / 4;  sz[5] = N / 4;  sz[6] = N / 4;
        x = top ? (N - 1 - a) : a;
        edge_lo = 0;
        for (int b = 0; b < 7; b++) begin
            if (x < edge_lo + sz[b]) return b;
            edge_lo += sz[b];
        end
        return 7;
    endfunction

    function automatic bit allowed(input int a, input bit top);
        return vpp_ok && (blk_exp(a, top) != 0 || boot_unlock);
    endfunction

    task automatic wcyc(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        junk = junk + 8'h47;
    endtask

    task automatic cmd(input logic [7:0] c);
        wcyc(addr, {junk, c});
    endtask

    task automatic settle();
        repeat (BC) @(negedge clk);
    endtask

    task automatic rd(input int a, input bit bm, input bit lsb);
        addr = AW'(a); byte_mode = bm; byte_lsb = lsb;
        #1;
    endtask

    task automatic upd(inout logic [15:0] w, input logic [15:0] d);
        if (!byte_mode)    w = d;
        else if (byte_lsb) w[15:8] = d[7:0];
        else               w[7:0] = d[7:0];
    endtask

    task automatic do_write(input int a, input logic [15:0] d);
        cmd(prog_alt ? 8'h10 : 8'h40);
        prog_alt = ~prog_alt;
        wcyc(AW'(a), d);
        if (allowed(a, 1'b1)) upd(shT[a], d);
        if (allowed(a, 1'b0)) upd(shB[a], d);
        settle();
    endtask

    task automatic do_erase(input int a, input logic [7:0] conf);
        cmd(8'h20);
        wcyc(AW'(a), {junk, conf});
        if (conf == 8'hD0) begin
            for (int i = 0; i < N; i++) begin
                if (allowed(a, 1'b1) && blk_exp(i, 1'b1) == blk_exp(a, 1'b1)) shT[i] = 16'hFFFF;
                if (allowed(a, 1'b0) && blk_exp(i, 1'b0) == blk_exp(a, 1'b0)) shB[i] = 16'hFFFF;
            end
        end
        settle();
    endtask

    task automatic chk_array(input string req);
        cmd(8'hFF);
        for (int a = 0; a < N; a++) begin
            rd(a, 1'b0, 1'b0);
            check(req, rdT, shT[a]);
            check(req, rdB, shB[a]);
        end
    endtask

    task automatic chk_stat(input string req, input logic [7:0] eT, input logic [7:0] eB);
        cmd(8'h70);
        rd(0, 1'b0, 1'b0);
        check(req, rdT, {8'h00, eT});
        check(req, rdB, {8'h00, eB});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 R10: after reset, ready with no errors.
        chk_stat("R1 R10 reset status", 8'h80, 8'h80);

        // R5 R3: program every address with distinct words.
        for (int a = 0; a < N; a++)
            do_write(a, 16'((a * 16'h0137 + 16'h1357) ^ (a << 9)));
        chk_array("R5 word program sweep");

        // R2: byte-lane reads of every word.
        for (int a = 0; a < N; a++) begin
            rd(a, 1'b1, 1'b0);
            check("R2 byte read low", rdT, {8'h00, shT[a][7:0]});
            rd(a, 1'b1, 1'b1);
            check("R2 byte read high", rdB, {8'h00, shB[a][15:8]});
        end

        // R3: unknown code leaves array mode in place.
        cmd(8'h00);
        rd(7, 1'b0, 1'b0);
        check("R3 unknown code ignored", rdT, shT[7]);

        // R6 R7: erase each block in turn over a zero fill.
        foreach (shT[k]) begin end
        for (int r = 0; r < 7; r++) begin
            int reps [7];
            reps[0] = 0;  reps[1] = 16; reps[2] = 32; reps[3] = 48;
            reps[4] = 60; reps[5] = 61; reps[6] = 62;
            for (int a = 0; a < N; a++) do_write(a, 16'h0000);
            do_erase(reps[r], 8'hD0);
            chk_array("R6 R7 block erase map");
        end

        // R5: byte-mode program touches one lane.
        do_erase(20, 8'hD0);
        byte_mode = 1'b1; byte_lsb = 1'b1;
        do_write(20, 16'h005A);
        byte_lsb = 1'b0;
        do_write(21, 16'h00C3);
        byte_mode = 1'b0;
        chk_array("R5 byte program lanes");

        // R11: busy window and commands ignored inside it.
        cmd(8'h50);
        cmd(8'h40);
        wcyc(AW'(9), 16'h1234);
        shT[9] = 16'h1234; shB[9] = 16'h1234;
        #1;
        check("R11 busy first cycle", rdT, 16'h0000);
        @(negedge clk);
        addr = AW'(0); wdata = {junk, 8'hFF}; wr_en = 1'b1;
        #1;
        check("R11 busy second cycle", rdT, 16'h0000);
        @(negedge clk);
        wr_en = 1'b0;
        for (int k = 2; k < BC; k++) begin
            #1;
            check("R11 busy inner cycle", rdB, 16'h0000);
            @(negedge clk);
        end
        #1;
        check("R11 ready after window, write ignored", rdT, 16'h0080);
        chk_array("R11 programmed after busy");

        // R4: identification codes.
        cmd(8'h90);
        rd(0, 1'b0, 1'b0);
        check("R4 maker code", rdT, 16'h002C);
        check("R4 maker code", rdB, 16'h002C);
        rd(1, 1'b0, 1'b0);
        check("R4 device top", rdT, 16'h44B0);
        check("R4 device bottom", rdB, 16'h44B1);
        rd(1, 1'b1, 1'b0);
        check("R4 device byte", rdT, 16'h00B0);
        byte_mode = 1'b0;

        // R8 R13: supply low refusals and sticky flags.
        vpp_ok = 1'b0;
        do_write(5, 16'hBEEF);
        chk_stat("R8 supply low program", 8'h98, 8'h98);
        cmd(8'hFF);
        chk_stat("R13 flags sticky", 8'h98, 8'h98);
        cmd(8'h50);
        chk_stat("R13 clear", 8'h80, 8'h80);
        do_erase(40, 8'hD0);
        chk_stat("R8 supply low erase", 8'hA8, 8'hA8);
        vpp_ok = 1'b1;
        chk_array("R8 no change");

        // R9: boot lock differs between the two builds.
        cmd(8'h50);
        boot_unlock = 1'b0;
        do_write(62, 16'h0F0F);
        chk_stat("R9 locked program", 8'h90, 8'h80);
        cmd(8'h50);
        do_erase(63, 8'hD0);
        chk_stat("R9 locked erase", 8'hA0, 8'h80);
        boot_unlock = 1'b1;
        chk_array("R9 lock effect");

        // R12: bad confirm byte.
        cmd(8'h50);
        do_erase(30, 8'h33);
        rd(0, 1'b0, 1'b0);
        check("R12 bad confirm status", rdT, 16'h00B0);
        chk_array("R12 nothing erased");

        // R1: reset keeps array, clears flags, selects array reads.
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(9, 1'b0, 1'b0);
        check("R1 array mode after reset", rdT, shT[9]);
        chk_stat("R1 flags cleared", 8'h80, 8'h80);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule